// File: doc/BRIEF.md
# Writeback Slot Allocator

This block picks a place for each finished instruction in a delayed writeback buffer that feeds the commit logic. The buffer is a grid of future cycles (rows) by write ports per cycle (columns). Slot index is cycle × width + port, and the occupancy bitmap and all slot indices use that numbering. On each request the allocator scans forward from a search cursor for the first slot that is neither marked busy in the incoming bitmap nor already handed out in the current epoch. It returns the cycle, port and tag of that slot and adds one to that cycle's placement count. If no slot is free, it raises an overflow flag instead of a grant.

The cursor and the record of slots handed out persist across requests until the next epoch clear. The clear marks the start of a new stage cycle and returns the cursor, the record and the counts to zero. Moving the buffer forward in time, and the commit logic, belong to neighbouring blocks.

Top module: `wb_slot_alloc`

## Requirements
- R1: While reset is low, and after it, until the first request: grant and overflow are 0, the returned cycle, port and tag are 0, and every per-cycle count is 0.
- R2: A request with a free slot at or beyond the cursor gives, in the cycle after the request edge, a grant naming the lowest-indexed such slot: cycle = index / WB_WIDTH, port = index mod WB_WIDTH. Occupancy bit i describes slot i.
- R3: The search tries all ports of one cycle in rising order before moving to port 0 of the next cycle.
- R4: A slot below the cursor is never granted, even when its occupancy bit is 0. After a grant, the cursor sits at the granted slot.
- R5: When no slot at or beyond the cursor is free, overflow is 1 and grant is 0 for that response. Cycle, port and tag read 0, and the cursor and counts do not change.
- R6: Each grant adds exactly one to the count of the granted cycle and leaves all other counts unchanged. Counts are WB_DEPTH fields of CNT_W bits, and cycle c sits in bits [c*CNT_W +: CNT_W].
- R7: A slot granted since the last clear is treated as busy by later requests, even when its occupancy bit is 0.
- R8: An epoch clear zeroes the cursor, the granted-slot record and all counts. A request in the same cycle as the clear already searches from slot 0 with an empty record.
- R9: The returned tag equals the tag presented with the request that was granted.
- R10: A cycle without a request yields grant 0 and overflow 0, and changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Epoch clear (start of a stage cycle) |
| req_i | input | 1 | Finish request |
| tag_i | input | TAG_W | Tag of the finishing instruction |
| occ_i | input | WB_WIDTH*WB_DEPTH | Occupancy bitmap, bit i = slot i |
| gnt_o | output | 1 | Slot granted for last request |
| ovf_o | output | 1 | No free slot for last request |
| gnt_cyc_o | output | CYC_W | Granted cycle |
| gnt_port_o | output | PORT_W | Granted port |
| gnt_tag_o | output | TAG_W | Tag placed in the granted slot |
| cnt_o | output | WB_DEPTH*CNT_W | Per-cycle placement counts |

## Verification
The bench first fills port 0 and then port 1 of cycle 0 to expose the wrap to the next cycle. A design that advanced cycles before ports would report port 0 of cycle 1 one step early. It then frees slots below the cursor through the bitmap. A design that restarted the search at slot 0 would grant one of them. It relies on slots granted earlier in the epoch while their bitmap bits stay 0, which catches a design that forgets its own placements and grants the same slot twice. It also clears in the same cycle as a request, at the tail of the buffer and with a fully busy bitmap. These cases catch a stale cursor, an off-by-one bound that grants past capacity, and an overflow that still moves counts.

// File: rtl/wbsa_pkg.sv
`timescale 1ns/1ps
package wbsa_pkg;
   // index width for a range of n values, never below one bit
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // width able to hold the values 0..n
   function automatic int unsigned cnt_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/wbsa_search.sv
`timescale 1ns/1ps
module wbsa_search
   import wbsa_pkg::*;
#(
   parameter int unsigned WB_WIDTH = 2,
   parameter int unsigned WB_DEPTH = 4,
   localparam int unsigned CAP    = WB_WIDTH * WB_DEPTH,
   localparam int unsigned IDX_W  = idx_bits(CAP),
   localparam int unsigned CYC_W  = idx_bits(WB_DEPTH),
   localparam int unsigned PORT_W = idx_bits(WB_WIDTH)
) (
   input  logic [CAP-1:0]    busy_i,
   input  logic [IDX_W-1:0]  start_i,
   output logic              found_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [CYC_W-1:0]  cyc_o,
   output logic [PORT_W-1:0] port_o
);
   logic [CAP-1:0] elig;

   // a slot is a candidate when free and not behind the start point
   for (genvar i = 0; i < CAP; i++) begin : g_elig
      assign elig[i] = !busy_i[i] && (IDX_W'(i) >= start_i);
   end

   // ports of a cycle first, then the next cycle: lowest index wins
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      cyc_o   = '0;
      port_o  = '0;
      for (int c = 0; c < int'(WB_DEPTH); c++) begin
         for (int p = 0; p < int'(WB_WIDTH); p++) begin
            if (!found_o && elig[c*WB_WIDTH + p]) begin
               found_o = 1'b1;
               idx_o   = IDX_W'(c*WB_WIDTH + p);
               cyc_o   = CYC_W'(c);
               port_o  = PORT_W'(p);
            end
         end
      end
   end
endmodule

// File: rtl/wbsa_counters.sv
`timescale 1ns/1ps
module wbsa_counters
   import wbsa_pkg::*;
#(
   parameter int unsigned WB_WIDTH = 2,
   parameter int unsigned WB_DEPTH = 4,
   localparam int unsigned CYC_W = idx_bits(WB_DEPTH),
   localparam int unsigned CNT_W = cnt_bits(WB_WIDTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_i,
   input  logic                      inc_i,
   input  logic [CYC_W-1:0]          inc_cyc_i,
   output logic [WB_DEPTH*CNT_W-1:0] cnt_o
);
   for (genvar c = 0; c < WB_DEPTH; c++) begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] base;
      logic             bump;

      assign base = clr_i ? '0 : cnt_q;
      assign bump = inc_i && (inc_cyc_i == CYC_W'(c));

      always_ff @(posedge clk) begin
         if (!rst_n) cnt_q <= '0;
         else        cnt_q <= bump ? base + CNT_W'(1) : base;
      end

      assign cnt_o[c*CNT_W +: CNT_W] = cnt_q;
   end
endmodule

// File: rtl/wb_slot_alloc.sv
`timescale 1ns/1ps
module wb_slot_alloc
   import wbsa_pkg::*;
#(
   parameter int unsigned WB_WIDTH = 2,
   parameter int unsigned WB_DEPTH = 4,
   parameter int unsigned TAG_W    = 8,
   localparam int unsigned CAP    = WB_WIDTH * WB_DEPTH,
   localparam int unsigned IDX_W  = idx_bits(CAP),
   localparam int unsigned CYC_W  = idx_bits(WB_DEPTH),
   localparam int unsigned PORT_W = idx_bits(WB_WIDTH),
   localparam int unsigned CNT_W  = cnt_bits(WB_WIDTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_i,
   input  logic                      req_i,
   input  logic [TAG_W-1:0]          tag_i,
   input  logic [CAP-1:0]            occ_i,
   output logic                      gnt_o,
   output logic                      ovf_o,
   output logic [CYC_W-1:0]          gnt_cyc_o,
   output logic [PORT_W-1:0]         gnt_port_o,
   output logic [TAG_W-1:0]          gnt_tag_o,
   output logic [WB_DEPTH*CNT_W-1:0] cnt_o
);
   // elaboration-time parameter checks
   if (WB_WIDTH < 1) begin : g_bad_width
      $error("wb_slot_alloc: WB_WIDTH must be at least 1");
   end
   if (WB_DEPTH < 1) begin : g_bad_depth
      $error("wb_slot_alloc: WB_DEPTH must be at least 1");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wb_slot_alloc: TAG_W must be at least 1");
   end

   logic [IDX_W-1:0]  cursor_q;
   logic [CAP-1:0]    placed_q;
   logic [IDX_W-1:0]  cursor_eff;
   logic [CAP-1:0]    placed_eff;
   logic [CAP-1:0]    busy;
   logic              found;
   logic [IDX_W-1:0]  hit_idx;
   logic [CYC_W-1:0]  hit_cyc;
   logic [PORT_W-1:0] hit_port;
   logic              hit;
   logic [CAP-1:0]    hit_mask;

   // a clear in this cycle already governs this cycle's search
   assign cursor_eff = clr_i ? '0 : cursor_q;
   assign placed_eff = clr_i ? '0 : placed_q;
   assign busy       = occ_i | placed_eff;

   wbsa_search #(
      .WB_WIDTH (WB_WIDTH),
      .WB_DEPTH (WB_DEPTH)
   ) u_search (
      .busy_i  (busy),
      .start_i (cursor_eff),
      .found_o (found),
      .idx_o   (hit_idx),
      .cyc_o   (hit_cyc),
      .port_o  (hit_port)
   );

   assign hit      = req_i && found;
   assign hit_mask = hit ? (CAP'(1) << hit_idx) : '0;

   // cursor and granted-slot record
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cursor_q <= '0;
         placed_q <= '0;
      end else begin
         cursor_q <= hit ? hit_idx : cursor_eff;
         placed_q <= placed_eff | hit_mask;
      end
   end

   // registered response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_o      <= 1'b0;
         ovf_o      <= 1'b0;
         gnt_cyc_o  <= '0;
         gnt_port_o <= '0;
         gnt_tag_o  <= '0;
      end else begin
         gnt_o      <= hit;
         ovf_o      <= req_i && !found;
         gnt_cyc_o  <= hit ? hit_cyc  : '0;
         gnt_port_o <= hit ? hit_port : '0;
         gnt_tag_o  <= hit ? tag_i    : '0;
      end
   end

   wbsa_counters #(
      .WB_WIDTH (WB_WIDTH),
      .WB_DEPTH (WB_DEPTH)
   ) u_counters (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr_i),
      .inc_i     (hit),
      .inc_cyc_i (hit_cyc),
      .cnt_o     (cnt_o)
   );
endmodule

// File: rtl/wbsa_chk.sv
`timescale 1ns/1ps
module wbsa_chk
   import wbsa_pkg::*;
#(
   parameter int unsigned WB_WIDTH = 2,
   parameter int unsigned WB_DEPTH = 4,
   parameter int unsigned TAG_W    = 8,
   localparam int unsigned CAP    = WB_WIDTH * WB_DEPTH,
   localparam int unsigned CYC_W  = idx_bits(WB_DEPTH),
   localparam int unsigned PORT_W = idx_bits(WB_WIDTH),
   localparam int unsigned CNT_W  = cnt_bits(WB_WIDTH)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      clr_i,
   input logic                      req_i,
   input logic [TAG_W-1:0]          tag_i,
   input logic [CAP-1:0]            occ_i,
   input logic                      gnt_o,
   input logic                      ovf_o,
   input logic [CYC_W-1:0]          gnt_cyc_o,
   input logic [PORT_W-1:0]         gnt_port_o,
   input logic [TAG_W-1:0]          gnt_tag_o,
   input logic [WB_DEPTH*CNT_W-1:0] cnt_o
);
   int total;
   always_comb begin
      total = 0;
      for (int c = 0; c < int'(WB_DEPTH); c++) total += int'(cnt_o[c*CNT_W +: CNT_W]);
   end

   // R5
   gnt_ovf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gnt_o && ovf_o));

   // R10
   no_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_i) |-> (!gnt_o && !ovf_o));

   // R2
   gnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_o |-> (int'(gnt_port_o) < int'(WB_WIDTH) && int'(gnt_cyc_o) < int'(WB_DEPTH)));

   // R9
   gnt_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_o |-> (gnt_tag_o == $past(tag_i)));

   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o && !$past(clr_i)) |-> (total == $past(total) + 1));

   // R5
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !$past(clr_i)) |-> (total == $past(total)));

   // R8
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr_i) && !gnt_o) |-> (total == 0));
endmodule

bind wb_slot_alloc wbsa_chk #(
   .WB_WIDTH (WB_WIDTH),
   .WB_DEPTH (WB_DEPTH),
   .TAG_W    (TAG_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr_i      (clr_i),
   .req_i      (req_i),
   .tag_i      (tag_i),
   .occ_i      (occ_i),
   .gnt_o      (gnt_o),
   .ovf_o      (ovf_o),
   .gnt_cyc_o  (gnt_cyc_o),
   .gnt_port_o (gnt_port_o),
   .gnt_tag_o  (gnt_tag_o),
   .cnt_o      (cnt_o)
);

// File: tb/wb_slot_alloc_test.sv
`timescale 1ns/1ps
module wb_slot_alloc_test;
   localparam int W = 2;
   localparam int D = 4;
   localparam int TW = 8;
   localparam int CAP = W * D;
   localparam int CW = 2;
   localparam int YW = 2;
   localparam int PW = 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            clr_i = 1'b0;
   logic            req_i = 1'b0;
   logic [TW-1:0]   tag_i = '0;
   logic [CAP-1:0]  occ_i = '0;
   logic            gnt_o, ovf_o;
   logic [YW-1:0]   gnt_cyc_o;
   logic [PW-1:0]   gnt_port_o;
   logic [TW-1:0]   gnt_tag_o;
   logic [D*CW-1:0] cnt_o;

   always #2.5 clk = ~clk;

   wb_slot_alloc #(.WB_WIDTH(W), .WB_DEPTH(D), .TAG_W(TW)) uut (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .req_i(req_i), .tag_i(tag_i),
      .occ_i(occ_i), .gnt_o(gnt_o), .ovf_o(ovf_o), .gnt_cyc_o(gnt_cyc_o),
      .gnt_port_o(gnt_port_o), .gnt_tag_o(gnt_tag_o), .cnt_o(cnt_o)
   );

   typedef struct {
      bit    gnt;
      bit    ovf;
      int    cyc;
      int    port;
      int    tag;
      int    cnt [D];
      string rq;
   } exp_t;

   exp_t q[$];
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference state, built from the requirements
   int m_cur = 0;
   bit m_placed [CAP];
   int m_cnt [D];

   task automatic chk(input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic step(input bit rv, input bit cl, input int tag,
                       input logic [CAP-1:0] occ, input string rq);
      exp_t e;
      int   hit;
      @(negedge clk);
      req_i = rv; clr_i = cl; tag_i = TW'(tag); occ_i = occ;
      if (cl) begin
         m_cur = 0;
         for (int i = 0; i < CAP; i++) m_placed[i] = 1'b0;
         for (int c = 0; c < D; c++) m_cnt[c] = 0;
      end
      e.gnt = 0; e.ovf = 0; e.cyc = 0; e.port = 0; e.tag = 0; e.rq = rq;
      if (rv) begin
         hit = -1;
         for (int i = m_cur; i < CAP; i++)
            if (hit < 0 && !occ[i] && !m_placed[i]) hit = i;
         if (hit >= 0) begin
            e.gnt = 1; e.cyc = hit / W; e.port = hit % W; e.tag = tag;
            m_placed[hit] = 1'b1; m_cur = hit; m_cnt[hit / W]++;
         end else begin
            e.ovf = 1;
         end
      end
      for (int c = 0; c < D; c++) e.cnt[c] = m_cnt[c];
      q.push_back(e);
   endtask

   // monitor: compare each response one step after its request edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.rq, "gnt", int'(gnt_o), int'(e.gnt));
            chk(e.rq, "ovf", int'(ovf_o), int'(e.ovf));
            chk(e.rq, "cyc", int'(gnt_cyc_o), e.cyc);
            chk(e.rq, "port", int'(gnt_port_o), e.port);
            chk(e.rq, "tag", int'(gnt_tag_o), e.tag);
            for (int c = 0; c < D; c++)
               chk(e.rq, "cnt", int'(cnt_o[c*CW +: CW]), e.cnt[c]);
         end
      end
   end

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      report();
   end

   initial begin
      for (int i = 0; i < CAP; i++) m_placed[i] = 1'b0;
      for (int c = 0; c < D; c++) m_cnt[c] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 during reset
      chk("R1", "gnt", int'(gnt_o), 0);
      chk("R1", "ovf", int'(ovf_o), 0);
      chk("R1", "cnt", int'(cnt_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "gnt after reset", int'(gnt_o), 0);
      chk("R1", "cnt after reset", int'(cnt_o), 0);

      // R2, R3, R7: fill ports of cycle 0 then wrap to cycle 1
      step(1, 1, 8'h11, 8'h00, "R2");
      step(1, 0, 8'h22, 8'h00, "R7");
      step(1, 0, 8'h33, 8'h00, "R3");
      step(0, 0, 8'h44, 8'hFF, "R10");
      step(1, 0, 8'h55, 8'h08, "R6");
      // R8: clear together with a request, busy bitmap holes
      step(1, 1, 8'h66, 8'h05, "R8");
      step(1, 0, 8'h77, 8'h05, "R2");
      step(0, 0, 8'h00, 8'h00, "R10");
      // R4: slots 0..2 freed in the bitmap but behind the cursor
      step(1, 1, 8'h81, 8'h07, "R4");
      step(1, 0, 8'h82, 8'h00, "R4");
      step(1, 0, 8'h83, 8'h00, "R9");
      // R5: everything busy
      step(1, 1, 8'h91, 8'hFF, "R5");
      step(0, 0, 8'h00, 8'h00, "R10");
      // R5: reach the last slot, then run off the end
      step(1, 1, 8'hA1, 8'h7F, "R2");
      step(1, 0, 8'hA2, 8'h00, "R5");
      step(1, 0, 8'hA3, 8'h00, "R5");
      // R6: walk a full epoch
      step(1, 1, 8'hB0, 8'h00, "R6");
      for (int k = 1; k < CAP; k++) step(1, 0, 8'hB0 + k, 8'h00, "R6");
      step(1, 0, 8'hBF, 8'h00, "R5");
      step(0, 0, 8'h00, 8'h00, "R10");
      step(0, 0, 8'h00, 8'h00, "R10");
      wait (q.size() == 0);
      @(negedge clk);
      report();
   end
endmodule